// File: doc/BRIEF.md
# Network Controller Bring-Up Sequencer

This block is the reset-time bus master of a network DMA controller. When reset is released it walks a short chain of pointers in memory to find where its system control block lives. First it reads a configuration record at a fixed address near the top of the 24-bit space. That record gives the data bus width for later transfers and the address of an intermediate pointer block. It then reads the intermediate block to get the base and the offset of the control block, and combines them into one 24-bit address. Last, it writes a zero over the block's busy word to finish the handshake.

After that write completes, the block raises an interrupt to tell the host it is ready. The interrupt stays up until the host pulses an acknowledge. The sequencer then settles in a ready state and makes no further bus accesses. Every access goes through a request/grant/done handshake on a 16-bit data port, and only one access is ever outstanding.

Top module: `netinit_seq`

## Requirements
- R1: While reset is asserted, `mem_req`, `irq` and `ready` are low. The first access after reset is a read of address 24'hFFFFF6, issued with `mem_narrow` low.
- R2: The configuration record is read at 24'hFFFFF6, 24'hFFFFF8 and 24'hFFFFFA, in that order. The intermediate pointer is bits 7:0 of the word at 24'hFFFFFA (pointer bits 23:16) joined with the word at 24'hFFFFF8 (pointer bits 15:0).
- R3: Bit 0 of the word read at 24'hFFFFF6 selects the bus width, where 1 means 8-bit. `narrow_mode` and `mem_narrow` carry this bit on every access after the first.
- R4: With intermediate pointer P, the block is read at P (busy word), P+2 (offset), P+4 (base bits 15:0) and P+6 (base bits 23:16 in data bits 7:0), in that order.
- R5: `ctl_addr` equals the base plus the zero-extended 16-bit offset, modulo 2^24. It holds this value by the time `irq` rises.
- R6: After the four reads, exactly one write is issued, to address P with data 16'h0000. `mem_we` is low on every other access.
- R7: `mem_req` stays high with a stable address until a cycle in which `mem_gnt` is high. The next request is raised in the cycle right after `mem_done`, never before.
- R8: `irq` rises in the cycle after the write's `mem_done` and stays high until `irq_ack` is seen. An `irq_ack` given while `irq` is low has no effect.
- R9: In the cycle after `irq_ack` is taken, `irq` is low and `ready` is high. `ready` then stays high and no further access is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Access request, held until granted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_narrow | output | 1 | 1 = access uses the 8-bit bus width |
| mem_gnt | input | 1 | Grant, one cycle per accepted request |
| mem_done | input | 1 | Access complete, read data valid |
| mem_rdata | input | 16 | Read data, sampled with `mem_done` |
| irq | output | 1 | Ready interrupt to the host |
| irq_ack | input | 1 | Host acknowledge pulse |
| ready | output | 1 | Initialization finished and acknowledged |
| ctl_addr | output | 24 | Resolved control block address |
| narrow_mode | output | 1 | Bus width selected by the configuration record |

## Verification
A new request is due one cycle after each `mem_done`. The `irq` rise is due one cycle after the final write's `mem_done`, and `irq` low with `ready` high is due one cycle after the acknowledge. The bench's memory model drives and samples on falling edges and counts rising edges between `mem_done` and the next visible request, so it checks each gap against exactly one cycle. Address, width flag and data are logged at the grant, when the design must hold them stable. `ctl_addr` is checked against a sum computed in the bench once `irq` is seen, including a case where the offset carries into the high byte and one where the sum wraps past 2^24.

// File: rtl/netinit_seq.sv
module netinit_seq #(
  parameter int          AW       = 24,
  parameter int          DW       = 16,
  parameter logic [23:0] CFG_ADDR = 24'hFFFFF6,
  parameter int          STEP     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_narrow,
  input  logic          mem_gnt,
  input  logic          mem_done,
  input  logic [DW-1:0] mem_rdata,
  output logic          irq,
  input  logic          irq_ack,
  output logic          ready,
  output logic [AW-1:0] ctl_addr,
  output logic          narrow_mode
);

  localparam logic [AW-1:0] STEP_A = AW'(STEP);
  localparam int            HIW    = AW - DW;

  typedef enum logic [3:0] {
    ST_CFG_FLAGS, ST_CFG_PLO, ST_CFG_PHI,
    ST_IB_BUSY, ST_IB_OFF, ST_IB_BLO, ST_IB_BHI,
    ST_IB_CLR, ST_SIGNAL, ST_READY
  } state_t;

  state_t        state;
  logic          live;
  logic          issuing;
  logic          first;
  logic          narrow_q;
  logic [AW-1:0] iptr;
  logic [DW-1:0] offset_q;
  logic [DW-1:0] base_lo;
  logic [AW-1:0] ctl_q;

  wire bus_phase = (state <= ST_IB_CLR);

  assign mem_req     = live && issuing && bus_phase;
  assign mem_we      = (state == ST_IB_CLR);
  assign mem_wdata   = '0;
  assign mem_narrow  = narrow_q && !first;
  assign narrow_mode = narrow_q;
  assign irq         = (state == ST_SIGNAL);
  assign ready       = (state == ST_READY);
  assign ctl_addr    = ctl_q;

  always_comb begin
    case (state)
      ST_CFG_FLAGS: mem_addr = CFG_ADDR;
      ST_CFG_PLO:   mem_addr = CFG_ADDR + STEP_A;
      ST_CFG_PHI:   mem_addr = CFG_ADDR + 2 * STEP_A;
      ST_IB_OFF:    mem_addr = iptr + STEP_A;
      ST_IB_BLO:    mem_addr = iptr + 2 * STEP_A;
      ST_IB_BHI:    mem_addr = iptr + 3 * STEP_A;
      default:      mem_addr = iptr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_CFG_FLAGS;
      live     <= 1'b0;
      issuing  <= 1'b1;
      first    <= 1'b1;
      narrow_q <= 1'b0;
      iptr     <= '0;
      offset_q <= '0;
      base_lo  <= '0;
      ctl_q    <= '0;
    end else begin
      live <= 1'b1;
      if (bus_phase && live) begin
        if (issuing) begin
          if (mem_gnt) issuing <= 1'b0;
        end else if (mem_done) begin
          issuing <= 1'b1;
          first   <= 1'b0;
          case (state)
            ST_CFG_FLAGS: begin narrow_q <= mem_rdata[0]; state <= ST_CFG_PLO; end
            ST_CFG_PLO:   begin iptr[DW-1:0] <= mem_rdata; state <= ST_CFG_PHI; end
            ST_CFG_PHI:   begin iptr[AW-1:DW] <= mem_rdata[HIW-1:0]; state <= ST_IB_BUSY; end
            ST_IB_BUSY:   state <= ST_IB_OFF;
            ST_IB_OFF:    begin offset_q <= mem_rdata; state <= ST_IB_BLO; end
            ST_IB_BLO:    begin base_lo <= mem_rdata; state <= ST_IB_BHI; end
            ST_IB_BHI:    begin
              ctl_q <= {mem_rdata[HIW-1:0], base_lo} + {{HIW{1'b0}}, offset_q};
              state <= ST_IB_CLR;
            end
            default:      state <= ST_SIGNAL;
          endcase
        end
      end else if (state == ST_SIGNAL && irq_ack) begin
        state <= ST_READY;
      end
    end
  end

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  assert_no_req_while_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !mem_req);

  assert_irq_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mem_done && mem_we));

  assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

  assert_ready_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!mem_req && !irq));

  assert_ready_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

endmodule

// File: tb/sim_netinit_seq.sv
module sim_netinit_seq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        mem_req, mem_we, mem_narrow, irq, ready, narrow_mode;
  logic [23:0] mem_addr, ctl_addr;
  logic [15:0] mem_wdata;
  logic        mem_gnt = 0, mem_done = 0, irq_ack = 0;
  logic [15:0] mem_rdata = 0;

  always #2.5 clk = ~clk;

  netinit_seq u0 (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_narrow(mem_narrow),
    .mem_gnt(mem_gnt), .mem_done(mem_done), .mem_rdata(mem_rdata),
    .irq(irq), .irq_ack(irq_ack), .ready(ready), .ctl_addr(ctl_addr),
    .narrow_mode(narrow_mode)
  );

  int nchk = 0, nfail = 0;
  int cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // memory image of the current scenario
  logic        m_b8;
  logic [23:0] m_ptr, m_base;
  logic [15:0] m_off;
  int          gdly = 0, ddly = 0;

  int          nacc = 0;
  logic [23:0] a_addr [16];
  logic        a_we [16], a_nar [16];
  logic [15:0] a_wd [16];
  int          a_gap [16];
  int          done_cyc = 0;

  function automatic logic [15:0] word_at(input logic [23:0] a);
    if (a == 24'hFFFFF6)      return {15'h52A5, m_b8};
    else if (a == 24'hFFFFF8) return m_ptr[15:0];
    else if (a == 24'hFFFFFA) return {8'hC3, m_ptr[23:16]};
    else if (a == m_ptr)      return 16'h0001;
    else if (a == m_ptr + 2)  return m_off;
    else if (a == m_ptr + 4)  return m_base[15:0];
    else if (a == m_ptr + 6)  return {8'h9E, m_base[23:16]};
    else                      return 16'hDEAD;
  endfunction

  initial begin
    forever begin
      if (rst_n && mem_req) begin
        logic [23:0] ad;
        repeat (gdly) @(negedge clk);
        ad = mem_addr;
        if (nacc < 16) begin
          a_addr[nacc] = mem_addr; a_we[nacc] = mem_we; a_nar[nacc] = mem_narrow;
          a_wd[nacc] = mem_wdata; a_gap[nacc] = cyc - done_cyc;
        end
        nacc++;
        mem_gnt = 1;
        @(negedge clk);
        mem_gnt = 0;
        repeat (ddly) @(negedge clk);
        mem_rdata = word_at(ad);
        mem_done = 1;
        done_cyc = cyc;
        @(negedge clk);
        mem_done = 0;
        mem_rdata = 16'h0;
      end else @(negedge clk);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    nacc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic test_reset_state();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(mem_req == 0, "R1 req low in reset", mem_req, 0);
    chk(irq == 0, "R1 irq low in reset", irq, 0);
    chk(ready == 0, "R1 ready low in reset", ready, 0);
  endtask

  task automatic run(input logic b8, input logic [23:0] ptr, input logic [15:0] off,
                     input logic [23:0] base, input int gd, input int dd, input bit early_ack);
    logic [23:0] exp_a [8];
    logic [23:0] exp_ctl;
    int t;
    m_b8 = b8; m_ptr = ptr; m_off = off; m_base = base; gdly = gd; ddly = dd;
    exp_ctl = base + {8'h0, off};
    exp_a[0] = 24'hFFFFF6; exp_a[1] = 24'hFFFFF8; exp_a[2] = 24'hFFFFFA;
    exp_a[3] = ptr; exp_a[4] = ptr + 2; exp_a[5] = ptr + 4; exp_a[6] = ptr + 6; exp_a[7] = ptr;
    do_reset();
    t = 0;
    while (!irq && t < 600) begin
      if (early_ack && t == 6) irq_ack = 1;
      else irq_ack = 0;
      @(negedge clk);
      t++;
    end
    irq_ack = 0;
    chk(irq == 1, "R8 irq raised", irq, 1);
    chk(nacc == 8, "R6 access count", nacc, 8);
    chk(a_nar[0] == 0, "R1 first access full width", a_nar[0], 0);
    for (int i = 0; i < 8; i++) begin
      if (i < 3) chk(a_addr[i] == exp_a[i], "R2 config address", a_addr[i], exp_a[i]);
      else chk(a_addr[i] == exp_a[i], "R4 block address", a_addr[i], exp_a[i]);
      chk(a_we[i] == (i == 7), "R6 write only last", a_we[i], i == 7);
      if (i > 0) begin
        chk(a_nar[i] == b8, "R3 narrow per access", a_nar[i], b8);
        chk(a_gap[i] == gd + 1, "R7 request one cycle after done", a_gap[i], gd + 1);
      end
    end
    chk(a_wd[7] == 16'h0000, "R6 busy clear data", a_wd[7], 0);
    chk(narrow_mode == b8, "R3 narrow_mode", narrow_mode, b8);
    chk(ctl_addr == exp_ctl, "R5 control block address", ctl_addr, exp_ctl);
    chk(done_cyc == cyc - 1, "R8 irq one cycle after write done", cyc - done_cyc, 1);
    repeat (4) @(negedge clk);
    chk(irq == 1 && ready == 0, "R8 irq held without ack", {irq, ready}, 2'b10);
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
    chk(irq == 0 && ready == 1, "R9 ready after ack", {irq, ready}, 2'b01);
    repeat (5) @(negedge clk);
    chk(ready == 1 && nacc == 8 && !mem_req, "R9 ready stays quiet", {ready, mem_req}, 2'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    test_reset_state();
    run(1'b0, 24'h001000, 16'h0040, 24'h020000, 0, 0, 0);
    run(1'b1, 24'h3A7F00, 16'hFFFF, 24'h12FFF0, 2, 1, 0);
    run(1'b0, 24'hFFFF00, 16'h8001, 24'hFFFFF0, 1, 3, 1);
    run(1'b1, 24'h000010, 16'h0000, 24'h000200, 0, 2, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule